// File: doc/BRIEF.md
# Dual-Select Static Word Memory with Split Data Buses

This block is a synchronous model of a small static memory. It has a write-data bus and a read-data bus, one address bus, two active-low select inputs, an active-low write strobe and an active-low output-gate input. The memory does anything only when both selects are low. A write stores the input word on the clock edge. A read returns the stored word one edge later. On-chip there is no tri-state bus, so the read bus comes with a qualifying drive flag. When the flag is low, the bus is held at zero.

The parameter `WRITE_THRU` fixes, at build time, what the read bus does while a write is in progress with the output gate open. With `WRITE_THRU` set to 1, it echoes the word being written. With `WRITE_THRU` set to 0, it stays undriven. An idle flag reports that the last sampled cycle had the memory deselected, so a power manager can use it.

`ADDR_W` sets the depth. The default of 11 keeps elaboration small. Setting `ADDR_W` to 14 gives the full 16384-word by 4-bit array (65,536 bits).

Top module: `sram_dual_sel`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits, and each address keeps its own word. This includes address 0 and the highest address.
- R2: A read sampled on clock edge N presents its word, with `dout_en` high, from edge N until edge N+1. No output changes before edge N.
- R3: If `sel_a_n` or `sel_b_n` is high at an edge, the following cycle has `dout_en` low and the array is not written, whatever `wr_n` and `oe_n` are.
- R4: With both selects low and both `wr_n` and `oe_n` high, the following cycle has `dout_en` low and the array is unchanged.
- R5: With both selects low, `wr_n` high and `oe_n` low, the following cycle drives the stored word at `addr` with `dout_en` high.
- R6: With both selects low and `wr_n` low, `din` is stored at `addr` on that edge. A later read of that address returns it.
- R7: During a write with `oe_n` high, the following cycle has `dout_en` low in both variants.
- R8: During a write with `oe_n` low, the following cycle behaves by variant. With WRITE_THRU=1, `dout_en` is high and `dout` equals the `din` of the write. With WRITE_THRU=0, `dout_en` is low.
- R9: Whenever `dout_en` is low, `dout` is all zeros.
- R10: `idle` is high after reset. It is high in the cycle after an edge where either select was high, and low in the cycle after an edge where both selects were low.
- R11: In the cycle that follows a write, raising a select together with `wr_n` leaves `dout_en` low, even in the WRITE_THRU=1 variant with `oe_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| sel_a_n | input | 1 | First select, active low |
| sel_b_n | input | 1 | Second select, active low |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | High when `dout` carries valid data |
| idle | output | 1 | High when the last sampled cycle was deselected |

## Verification
The bench runs both variants side by side on the same stimulus. A mix-up of the write-through choice therefore shows up as one instance driving where it should not, or echoing a stale word.

The bench writes with only one select low and then reads the address back. A design that ANDs the selects wrongly would overwrite the word.

The bench releases a select together with the write strobe. A design that holds the echo one extra cycle would leave `dout_en` high.

It checks the bus value on every undriven cycle. Reading the extreme addresses exposes any slicing error in the address path.

// File: rtl/sram_dual_sel_pkg.sv
package sram_dual_sel_pkg;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_INHIBIT = 2'd1,
    OP_READ    = 2'd2,
    OP_WRITE   = 2'd3
  } op_e;

  // Classify one sampled cycle from the control pins.
  function automatic op_e classify(input logic sa_n, input logic sb_n,
                                   input logic w_n, input logic g_n);
    if (sa_n || sb_n) return OP_IDLE;
    if (!w_n)         return OP_WRITE;
    if (!g_n)         return OP_READ;
    return OP_INHIBIT;
  endfunction

  // Does the read bus carry data after a cycle of this kind?
  function automatic logic bus_driven(input op_e op, input logic g_n,
                                      input logic thru);
    return (op == OP_READ) || (op == OP_WRITE && !g_n && thru);
  endfunction

endpackage

// File: rtl/sram_dual_sel_decode.sv
module sram_dual_sel_decode
  import sram_dual_sel_pkg::*;
(
  input  logic sel_a_n,
  input  logic sel_b_n,
  input  logic wr_n,
  input  logic oe_n,
  output op_e  op,
  output logic sel_ok,
  output logic wr_fire,
  output logic rd_fire
);

  always_comb begin
    op      = classify(sel_a_n, sel_b_n, wr_n, oe_n);
    sel_ok  = (op != OP_IDLE);
    wr_fire = (op == OP_WRITE);
    rd_fire = (op == OP_READ);
  end

endmodule

// File: rtl/sram_dual_sel_store.sv
module sram_dual_sel_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // Synchronous read port; a write and a read never share a cycle at the top.
  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    rdata <= cells[addr];
  end

endmodule

// File: rtl/sram_dual_sel_out.sv
module sram_dual_sel_out
  import sram_dual_sel_pkg::*;
#(
  parameter int DATA_W     = 4,
  parameter bit WRITE_THRU = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              idle
);

  logic              thru_ok;
  op_e               op_q;
  logic              oe_n_q;
  logic [DATA_W-1:0] din_q;

  generate
    if (WRITE_THRU) begin : g_echo
      assign thru_ok = 1'b1;
    end else begin : g_float
      assign thru_ok = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      oe_n_q <= 1'b1;
      din_q  <= '0;
    end else begin
      op_q   <= op;
      oe_n_q <= oe_n;
      din_q  <= din;
    end
  end

  always_comb begin
    dout_en = bus_driven(op_q, oe_n_q, thru_ok);
    idle    = (op_q == OP_IDLE);
    if (!dout_en)            dout = '0;
    else if (op_q == OP_READ) dout = rdata;
    else                     dout = din_q;
  end

endmodule

// File: rtl/sram_dual_sel.sv
module sram_dual_sel
  import sram_dual_sel_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 4,
  parameter bit WRITE_THRU = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              idle
);

  op_e               op;
  logic              sel_ok;
  logic              wr_fire;
  logic              rd_fire;
  logic [DATA_W-1:0] rdata;

  sram_dual_sel_decode u_dec (
    .sel_a_n (sel_a_n),
    .sel_b_n (sel_b_n),
    .wr_n    (wr_n),
    .oe_n    (oe_n),
    .op      (op),
    .sel_ok  (sel_ok),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire)
  );

  sram_dual_sel_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .we    (wr_fire),
    .addr  (addr),
    .wdata (din),
    .rdata (rdata)
  );

  sram_dual_sel_out #(.DATA_W(DATA_W), .WRITE_THRU(WRITE_THRU)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .oe_n    (oe_n),
    .din     (din),
    .rdata   (rdata),
    .dout    (dout),
    .dout_en (dout_en),
    .idle    (idle)
  );

endmodule

// File: rtl/sram_dual_sel_chk.sv
module sram_dual_sel_chk #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 4,
  parameter bit WRITE_THRU = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_a_n,
  input logic              sel_b_n,
  input logic              wr_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              idle,
  input logic              sel_ok,
  input logic              wr_fire,
  input logic              rd_fire
);

  localparam logic THRU = WRITE_THRU;

  logic both_low;
  assign both_low = !sel_a_n && !sel_b_n;

  assert_standby_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a_n || sel_b_n) |=> !dout_en);

  assert_inhibit_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (both_low && wr_n && oe_n) |=> !dout_en);

  assert_read_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> dout_en);

  assert_write_gate_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && oe_n) |=> !dout_en);

  assert_write_gate_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !oe_n) |=> (dout_en == THRU) && (!THRU || dout == $past(din)));

  assert_zero_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));

  assert_idle_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ok |=> !idle);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !dout_en);

  logic unused_ok;
  assign unused_ok = ^addr;

endmodule

bind sram_dual_sel sram_dual_sel_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_THRU(WRITE_THRU)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
  .wr_n(wr_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout),
  .dout_en(dout_en), .idle(idle), .sel_ok(sel_ok), .wr_fire(wr_fire),
  .rd_fire(rd_fire)
);

// File: tb/sim_sram_dual_sel.sv
`timescale 1ns/1ps
module sim_sram_dual_sel;

  localparam int AW = 11;
  localparam int DW = 4;
  localparam int TOP = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_a_n = 1'b1, sel_b_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout_t, dout_z;
  logic          en_t, en_z, idle_t, idle_z;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic [DW-1:0] model [1 << AW];

  always #2.5 clk = ~clk;

  sram_dual_sel #(.ADDR_W(AW), .DATA_W(DW), .WRITE_THRU(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
    .wr_n(wr_n), .oe_n(oe_n), .addr(addr), .din(din),
    .dout(dout_t), .dout_en(en_t), .idle(idle_t));

  sram_dual_sel #(.ADDR_W(AW), .DATA_W(DW), .WRITE_THRU(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
    .wr_n(wr_n), .oe_n(oe_n), .addr(addr), .din(din),
    .dout(dout_z), .dout_en(en_z), .idle(idle_z));

  task automatic chk(input string req, input string what,
                     input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual {idle,en,dout}=%b expected %b", req, what, act, exp);
    end
  endtask

  // One cycle: drive at a falling edge, let one rising edge pass, check outputs.
  task automatic step(input string req, input logic a, input logic b,
                      input logic w, input logic g,
                      input logic [AW-1:0] ad, input logic [DW-1:0] d);
    logic sel, rd, wrt;
    logic [DW-1:0] stored;
    logic [5:0] exp_t, exp_z;
    sel = !a && !b;
    rd  = sel && w && !g;
    wrt = sel && !w;
    stored = model[ad];
    exp_t = {!sel, 1'b0, 4'h0};
    exp_z = exp_t;
    if (rd) begin
      exp_t = {1'b0, 1'b1, stored};
      exp_z = exp_t;
    end else if (wrt && !g) begin
      exp_t = {1'b0, 1'b1, d};
    end
    sel_a_n = a; sel_b_n = b; wr_n = w; oe_n = g; addr = ad; din = d;
    @(negedge clk);
    if (wrt) model[ad] = d;
    chk(req, "write-through", {idle_t, en_t, dout_t}, exp_t);
    chk(req, "floating", {idle_z, en_z, dout_z}, exp_z);
  endtask

  task automatic t_reset;
    chk("R10", "reset thru", {idle_t, en_t, dout_t}, 6'b100000);
    chk("R9", "reset float", {idle_z, en_z, dout_z}, 6'b100000);
  endtask

  task automatic t_fill_read; // R1 R2 R5 R6
    step("R6", 0, 0, 0, 1, '0, 4'h9);
    step("R6", 0, 0, 0, 1, AW'(TOP), 4'h6);
    for (int i = 1; i < 9; i++) step("R6", 0, 0, 0, 1, AW'(i * 37), DW'(i + 3));
    step("R1", 0, 0, 1, 0, '0, '0);
    step("R1", 0, 0, 1, 0, AW'(TOP), '0);
    for (int i = 1; i < 9; i++) step("R5", 0, 0, 1, 0, AW'(i * 37), '0);
    step("R2", 0, 0, 1, 0, '0, '0);
  endtask

  task automatic t_standby; // R3 R10
    step("R6", 0, 0, 0, 1, AW'(5), 4'hA);
    step("R3", 1, 0, 0, 0, AW'(5), 4'h3);
    step("R3", 0, 1, 0, 0, AW'(5), 4'h4);
    step("R3", 1, 1, 1, 0, AW'(5), 4'h0);
    step("R3", 0, 0, 1, 0, AW'(5), '0);
    step("R10", 0, 1, 1, 0, AW'(5), '0);
  endtask

  task automatic t_inhibit; // R4
    step("R4", 0, 0, 1, 1, AW'(5), 4'hF);
    step("R4", 0, 0, 1, 0, AW'(5), '0);
  endtask

  task automatic t_write_gate; // R7 R8
    step("R7", 0, 0, 0, 1, AW'(77), 4'hC);
    step("R8", 0, 0, 0, 0, AW'(78), 4'h5);
    step("R8", 0, 0, 0, 0, AW'(79), 4'hE);
    step("R8", 0, 0, 1, 0, AW'(78), '0);
    step("R7", 0, 0, 1, 0, AW'(77), '0);
  endtask

  task automatic t_release; // R11 R9
    step("R8", 0, 0, 0, 0, AW'(90), 4'h7);
    step("R11", 1, 0, 1, 0, AW'(90), 4'h7);
    step("R8", 0, 0, 0, 0, AW'(91), 4'hB);
    step("R11", 0, 1, 1, 0, AW'(91), 4'hB);
    step("R9", 0, 0, 1, 0, AW'(91), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill_read();
    t_standby();
    t_inhibit();
    t_write_gate();
    t_release();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule